// File: doc/BRIEF.md
# RS-485 Automatic Transmit Enable

This block sits on the transmit line of a processor UART that has no direction-control output of its own. The serial line passes through the block unchanged. The block watches the line and produces a registered transmit-enable for an RS-485 half-duplex transceiver. The enable comes from the line alone. A falling edge on the idle-high line starts a character. The block then counts a programmed number of bit periods and releases the enable half a bit period after the nominal end of the final stop bit.

Software sets two registers through a write-only port. The first holds the bit period in system clock cycles. The second holds the character format (data length, parity, one or two stop bits) and a disable bit. The block derives the number of bits per character from the format. A start bit that appears during the stop period of the current character, or during the release margin, restarts the count. The enable therefore stays high through back-to-back characters. A configuration written while a character is in progress is used only from the next idle period on.

Top module: `rs485_txen_ctrl`

## Requirements
- R1: `bus_txd_o` always equals `uart_txd_i`, with no delay and no register in between.
- R2: After reset `txen_o` is low, the bit period is `RST_DIV` cycles, and the format is 8 data bits, no parity, one stop bit, enabled.
- R3: While idle and enabled, a falling edge on `uart_txd_i` that the last clock edge has not yet seen raises `txen_o` on the third rising clock edge after it (two synchroniser flops, then the output register). The enable is low before that edge.
- R4: Bits per character N = 1 + D + P + S. D is 5 + fmt[2:0] for codes 0..4, and 9 for codes 5..7. P = fmt[3] (parity on). S = 2 if fmt[4] is set, else 1. For one isolated character, `txen_o` stays high for exactly N*div + floor(div/2) clock cycles.
- R5: Falling edges inside the data and parity bits do not restart or extend the frame. A character rich in transitions gives the same enable length as one without transitions.
- R6: A start bit that arrives exactly at the end of the last stop bit begins a new character with no gap in `txen_o`. K such characters give one pulse of K*N*div + floor(div/2) cycles.
- R7: A start bit that arrives within the half-bit release margin restarts counting, so the pulse stays continuous. A start bit that arrives after the margin gives two separate pulses.
- R8: fmt[7] = 1 forces `txen_o` low on the second clock edge after the write and ignores line activity while it stays set.
- R9: Divisor or format writes made while a character is in progress do not change that character's enable length. They apply to the next character.
- R10: A divisor value below 2 is treated as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uart_txd_i | input | 1 | Transmit line from the processor UART (idle high) |
| bus_txd_o | output | 1 | Same line passed on to the transceiver |
| txen_o | output | 1 | Registered transceiver driver enable |
| cfg_wr_i | input | 1 | Register write strobe, one cycle |
| cfg_sel_i | input | 1 | 0 selects the divisor register, 1 selects the format register |
| cfg_wdata_i | input | DIV_W | Write data; the format register uses bits [7:0] |

## Verification
The hardest case to reach is a start bit that lands inside the narrow release margin after the last stop bit. Only a few clock cycles separate a restart from a dropped enable. The bench builds each frame on the line itself with an exact cycle count per bit, then leaves the line idle for a chosen number of cycles before the next start bit. It checks one gap shorter than half a bit period and one longer. A second hard case is a register write that lands in the middle of a character. The bench forks the write alongside the frame at a fixed cycle offset, so the write falls inside an active character.

// File: rtl/rs485_txen_pkg.sv
package rs485_txen_pkg;

   localparam int FMT_W         = 8;
   localparam int FMT_LEN_LSB   = 0;
   localparam int FMT_LEN_W     = 3;
   localparam int FMT_PAR_BIT   = 3;
   localparam int FMT_STOP2_BIT = 4;
   localparam int FMT_OFF_BIT   = 7;
   localparam int BITS_W        = 4;

   localparam logic [FMT_W-1:0] FMT_RESET = 8'h03;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FRAME = 2'd1,
      ST_TAIL  = 2'd2
   } txen_state_e;

   function automatic logic [BITS_W-1:0] frame_bits(
      input logic [FMT_LEN_W-1:0] len_code,
      input logic                 par_on,
      input logic                 two_stop
   );
      logic [BITS_W-1:0] dbits;
      dbits = (len_code > 3'd4) ? 4'd9 : (4'd5 + {1'b0, len_code});
      return 4'd1 + dbits + {3'b000, par_on} + (two_stop ? 4'd2 : 4'd1);
   endfunction

endpackage

// File: rtl/rs485_txen_sync.sv
module rs485_txen_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rs485_txen_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] chain_q;

   for (genvar i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b1;
            else        chain_q[0] <= line_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b1;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   // The last synchronised stage is low while the stage after it still holds high.
   assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];

endmodule

// File: rtl/rs485_txen_cfg.sv
module rs485_txen_cfg
   import rs485_txen_pkg::*;
#(
   parameter int DIV_W   = 16,
   parameter int RST_DIV = 50
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic              sel_i,
   input  logic [DIV_W-1:0]  wdata_i,
   input  logic              load_i,
   output logic [DIV_W-1:0]  div_o,
   output logic [BITS_W-1:0] nbits_o,
   output logic              stop2_o,
   output logic              off_o
);
   localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);
   localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(RST_DIV);

   if (DIV_W < FMT_W) begin : g_bad_width
      $error("rs485_txen_cfg: DIV_W must hold the format register");
   end
   if (RST_DIV < 2) begin : g_bad_rst
      $error("rs485_txen_cfg: RST_DIV must be at least 2");
   end

   logic [DIV_W-1:0] div_sh_q, div_act_q;
   logic [FMT_W-1:0] fmt_sh_q, fmt_act_q;

   // Registers that software writes.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_sh_q <= DIV_RST;
         fmt_sh_q <= FMT_RESET;
      end else if (wr_i) begin
         if (sel_i) fmt_sh_q <= wdata_i[FMT_W-1:0];
         else       div_sh_q <= wdata_i;
      end
   end

   // Working copies: refreshed only while the timer is idle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_act_q <= DIV_RST;
         fmt_act_q <= FMT_RESET;
      end else if (load_i) begin
         div_act_q <= (div_sh_q < DIV_MIN) ? DIV_MIN : div_sh_q;
         fmt_act_q <= fmt_sh_q;
      end
   end

   assign div_o   = div_act_q;
   assign nbits_o = frame_bits(fmt_act_q[FMT_LEN_LSB +: FMT_LEN_W],
                               fmt_act_q[FMT_PAR_BIT],
                               fmt_act_q[FMT_STOP2_BIT]);
   assign stop2_o = fmt_act_q[FMT_STOP2_BIT];
   // The disable bit acts at once and bypasses the idle-only refresh.
   assign off_o   = fmt_sh_q[FMT_OFF_BIT];

endmodule

// File: rtl/rs485_txen_timer.sv
module rs485_txen_timer
   import rs485_txen_pkg::*;
#(
   parameter int DIV_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              off_i,
   input  logic              start_i,
   input  logic [DIV_W-1:0]  div_i,
   input  logic [BITS_W-1:0] nbits_i,
   input  logic              stop2_i,
   output logic              txen_o,
   output logic              idle_o,
   output txen_state_e       state_o,
   output logic [BITS_W-1:0] bit_o,
   output logic [DIV_W-1:0]  cyc_o
);
   txen_state_e       st_q, st_d;
   logic [BITS_W-1:0] bit_q, bit_d;
   logic [DIV_W-1:0]  cyc_q, cyc_d;
   logic              txen_q;

   logic [DIV_W-1:0]  half;
   logic [BITS_W-1:0] stop_first;
   logic              in_stop, bit_done, last_bit, tail_done;

   assign half       = div_i >> 1;
   assign stop_first = nbits_i - (stop2_i ? 4'd2 : 4'd1);
   assign in_stop    = (bit_q >= stop_first);
   assign bit_done   = (cyc_q == div_i - 1'b1);
   assign last_bit   = (bit_q == nbits_i - 1'b1);
   assign tail_done  = (cyc_q == half - 1'b1);

   always_comb begin
      st_d  = st_q;
      bit_d = bit_q;
      cyc_d = cyc_q;
      if (off_i) begin
         st_d  = ST_IDLE;
         bit_d = '0;
         cyc_d = '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  st_d  = ST_FRAME;
                  bit_d = '0;
                  cyc_d = '0;
               end
            end
            ST_FRAME: begin
               if (start_i && in_stop) begin
                  bit_d = '0;
                  cyc_d = '0;
               end else if (bit_done) begin
                  cyc_d = '0;
                  if (last_bit) st_d = ST_TAIL;
                  else          bit_d = bit_q + 1'b1;
               end else begin
                  cyc_d = cyc_q + 1'b1;
               end
            end
            ST_TAIL: begin
               if (start_i) begin
                  st_d  = ST_FRAME;
                  bit_d = '0;
                  cyc_d = '0;
               end else if (tail_done) begin
                  st_d  = ST_IDLE;
                  bit_d = '0;
                  cyc_d = '0;
               end else begin
                  cyc_d = cyc_q + 1'b1;
               end
            end
            default: begin
               st_d  = ST_IDLE;
               bit_d = '0;
               cyc_d = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         bit_q  <= '0;
         cyc_q  <= '0;
         txen_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         bit_q  <= bit_d;
         cyc_q  <= cyc_d;
         txen_q <= (st_d != ST_IDLE);
      end
   end

   assign txen_o  = txen_q;
   assign idle_o  = (st_q == ST_IDLE);
   assign state_o = st_q;
   assign bit_o   = bit_q;
   assign cyc_o   = cyc_q;

endmodule

// File: rtl/rs485_txen_ctrl.sv
module rs485_txen_ctrl
   import rs485_txen_pkg::*;
#(
   parameter int DIV_W       = 16,
   parameter int RST_DIV     = 50,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             uart_txd_i,
   output logic             bus_txd_o,
   output logic             txen_o,
   input  logic             cfg_wr_i,
   input  logic             cfg_sel_i,
   input  logic [DIV_W-1:0] cfg_wdata_i
);
   logic              start_pulse;
   logic              idle_now;
   logic              off_now;
   logic              stop2_act;
   logic [DIV_W-1:0]  div_act;
   logic [BITS_W-1:0] nbits_act;
   txen_state_e       state_q;
   logic [BITS_W-1:0] bit_q;
   logic [DIV_W-1:0]  cyc_q;

   assign bus_txd_o = uart_txd_i;

   rs485_txen_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (uart_txd_i),
      .fall_o (start_pulse)
   );

   rs485_txen_cfg #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (cfg_wr_i),
      .sel_i   (cfg_sel_i),
      .wdata_i (cfg_wdata_i),
      .load_i  (idle_now),
      .div_o   (div_act),
      .nbits_o (nbits_act),
      .stop2_o (stop2_act),
      .off_o   (off_now)
   );

   rs485_txen_timer #(.DIV_W(DIV_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .off_i   (off_now),
      .start_i (start_pulse),
      .div_i   (div_act),
      .nbits_i (nbits_act),
      .stop2_i (stop2_act),
      .txen_o  (txen_o),
      .idle_o  (idle_now),
      .state_o (state_q),
      .bit_o   (bit_q),
      .cyc_o   (cyc_q)
   );

endmodule

// File: rtl/rs485_txen_chk.sv
module rs485_txen_chk
   import rs485_txen_pkg::*;
#(
   parameter int DIV_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              txen_o,
   input logic              start_pulse,
   input logic              off_now,
   input txen_state_e       state_q,
   input logic [BITS_W-1:0] bit_q,
   input logic [BITS_W-1:0] nbits_act,
   input logic [DIV_W-1:0]  cyc_q,
   input logic [DIV_W-1:0]  div_act
);
   // R3: the enable rises only after a detected start edge.
   assert_rise_from_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(txen_o) |-> $past(start_pulse));

   // R4: the bit and cycle counters stay within the active frame geometry.
   assert_count_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |-> (bit_q < nbits_act) && (cyc_q < div_act));

   // R7: the enable is released only from the release margin or by the disable bit.
   assert_release_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(txen_o) |-> ($past(state_q) == ST_TAIL) || $past(off_now));

   // R8: while disabled the enable is low from the next edge on.
   assert_off_forces_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      off_now |=> !txen_o);

   // R9: the working configuration does not move during a character.
   assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q != ST_IDLE) && ($past(state_q) != ST_IDLE)) |->
         ($stable(nbits_act) && $stable(div_act)));

endmodule

bind rs485_txen_ctrl rs485_txen_chk #(.DIV_W(DIV_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .txen_o      (txen_o),
   .start_pulse (start_pulse),
   .off_now     (off_now),
   .state_q     (state_q),
   .bit_q       (bit_q),
   .nbits_act   (nbits_act),
   .cyc_q       (cyc_q),
   .div_act     (div_act)
);

// File: tb/tb_rs485_txen_ctrl.sv
`timescale 1ns/1ps
module tb_rs485_txen_ctrl;
   localparam int DIV_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             uart_txd_i = 1'b1;
   logic             bus_txd_o;
   logic             txen_o;
   logic             cfg_wr_i = 1'b0;
   logic             cfg_sel_i = 1'b0;
   logic [DIV_W-1:0] cfg_wdata_i = '0;

   int checks = 0;
   int failures = 0;
   int run_len = 0;
   int last_len = 0;
   int runs = 0;

   always #2 clk = ~clk;

   rs485_txen_ctrl #(.DIV_W(DIV_W), .RST_DIV(50), .SYNC_STAGES(2)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .uart_txd_i  (uart_txd_i),
      .bus_txd_o   (bus_txd_o),
      .txen_o      (txen_o),
      .cfg_wr_i    (cfg_wr_i),
      .cfg_sel_i   (cfg_sel_i),
      .cfg_wdata_i (cfg_wdata_i)
   );

   // Pulse monitor on the enable, sampled away from the active edge.
   always @(negedge clk) begin
      if (txen_o) run_len <= run_len + 1;
      else if (run_len != 0) begin
         last_len <= run_len;
         runs     <= runs + 1;
         run_len  <= 0;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int nbits(input int code, input int par, input int two);
      return 1 + ((code > 4) ? 9 : 5 + code) + par + (two != 0 ? 2 : 1);
   endfunction

   task automatic wr(input logic sel, input int val);
      cfg_wr_i    = 1'b1;
      cfg_sel_i   = sel;
      cfg_wdata_i = DIV_W'(val);
      @(negedge clk);
      cfg_wr_i    = 1'b0;
   endtask

   task automatic set_fmt(input int code, input int par, input int two, input int off);
      wr(1'b1, code | (par << 3) | (two << 4) | (off << 7));
   endtask

   // Drives one character on the line, every bit held div cycles, even parity.
   task automatic send_char(input int data, input int code, input int par,
                            input int two, input int div);
      int dn;
      int p;
      dn = (code > 4) ? 9 : 5 + code;
      p = 0;
      uart_txd_i = 1'b0;
      repeat (div) @(negedge clk);
      for (int i = 0; i < dn; i++) begin
         uart_txd_i = data[i];
         p = p ^ data[i];
         repeat (div) @(negedge clk);
      end
      if (par != 0) begin
         uart_txd_i = p[0];
         repeat (div) @(negedge clk);
      end
      uart_txd_i = 1'b1;
      repeat ((two != 0 ? 2 : 1) * div) @(negedge clk);
   endtask

   task automatic settle(input int div);
      repeat (3 * div + 8) @(negedge clk);
   endtask

   task automatic t_reset;
      check("R2 txen after reset", int'(txen_o), 0);
      check("R1 idle line passthrough", int'(bus_txd_o), 1);
      // Default divisor 50, 8N1: 10*50 + 25.
      send_char(8'h00, 3, 0, 0, 50);
      settle(50);
      check("R2 default frame length", last_len, 525);
   endtask

   task automatic t_latency;
      wr(1'b0, 8);
      fork
         send_char(8'hA5, 3, 0, 0, 8);
         begin
            @(negedge clk);
            check("R1 low bit passthrough", int'(bus_txd_o), 0);
            @(negedge clk);
            check("R3 enable low before third edge", int'(txen_o), 0);
            @(negedge clk);
            check("R3 enable high at third edge", int'(txen_o), 1);
         end
      join
      settle(8);
      check("R4 8N1 div8 length", last_len, 84);
   endtask

   task automatic t_formats;
      int c[4] = '{0, 2, 4, 7};
      int p[4] = '{0, 1, 0, 1};
      int s[4] = '{0, 1, 1, 0};
      for (int k = 0; k < 4; k++) begin
         set_fmt(c[k], p[k], s[k], 0);
         send_char(8'h3C, c[k], p[k], s[k], 8);
         settle(8);
         check($sformatf("R4 format code=%0d par=%0d two=%0d", c[k], p[k], s[k]),
               last_len, nbits(c[k], p[k], s[k]) * 8 + 4);
      end
      set_fmt(3, 0, 0, 0);
   endtask

   task automatic t_data_edges;
      int r0;
      r0 = runs;
      send_char(8'h55, 3, 1, 0, 8);
      set_fmt(3, 1, 0, 0);
      settle(8);
      r0 = runs;
      send_char(8'h55, 3, 1, 0, 8);
      settle(8);
      check("R5 toggling data one pulse", runs - r0, 1);
      check("R5 toggling data length", last_len, 11 * 8 + 4);
      set_fmt(3, 0, 0, 0);
   endtask

   task automatic t_back2back;
      int r0;
      r0 = runs;
      send_char(8'h12, 3, 0, 0, 8);
      send_char(8'h34, 3, 0, 0, 8);
      send_char(8'h00, 3, 0, 0, 8);
      settle(8);
      check("R6 back-to-back one pulse", runs - r0, 1);
      check("R6 back-to-back length", last_len, 3 * 80 + 4);
   endtask

   task automatic t_tail;
      int r0;
      r0 = runs;
      send_char(8'h0F, 3, 0, 0, 8);
      repeat (2) @(negedge clk);
      send_char(8'hF0, 3, 0, 0, 8);
      settle(8);
      check("R7 start inside margin one pulse", runs - r0, 1);
      check("R7 start inside margin length", last_len, 80 + 2 + 80 + 4);
      r0 = runs;
      send_char(8'h0F, 3, 0, 0, 8);
      repeat (8) @(negedge clk);
      send_char(8'hF0, 3, 0, 0, 8);
      settle(8);
      check("R7 start after margin two pulses", runs - r0, 2);
      check("R7 start after margin length", last_len, 84);
   endtask

   task automatic t_disable;
      int r0;
      fork
         send_char(8'h00, 3, 0, 0, 8);
         begin
            repeat (30) @(negedge clk);
            check("R8 enable high before disable", int'(txen_o), 1);
            set_fmt(3, 0, 0, 1);
            @(negedge clk);
            check("R8 enable low after disable", int'(txen_o), 0);
         end
      join
      settle(8);
      r0 = runs;
      send_char(8'h00, 3, 0, 0, 8);
      settle(8);
      check("R8 disabled line ignored", runs - r0, 0);
      check("R8 disabled enable stays low", int'(txen_o), 0);
      set_fmt(3, 0, 0, 0);
      send_char(8'h00, 3, 0, 0, 8);
      settle(8);
      check("R8 re-enabled length", last_len, 84);
   endtask

   task automatic t_cfg_active;
      fork
         send_char(8'h81, 3, 0, 0, 8);
         begin
            repeat (20) @(negedge clk);
            wr(1'b0, 12);
            set_fmt(0, 0, 0, 0);
         end
      join
      settle(8);
      check("R9 mid-frame write ignored", last_len, 84);
      send_char(8'h15, 0, 0, 0, 12);
      settle(12);
      check("R9 new config next frame", last_len, 7 * 12 + 6);
      set_fmt(3, 0, 0, 0);
   endtask

   task automatic t_min_div;
      wr(1'b0, 1);
      send_char(8'h00, 3, 0, 0, 2);
      settle(4);
      check("R10 divisor 1 acts as 2", last_len, 21);
      wr(1'b0, 0);
      send_char(8'h00, 3, 0, 0, 2);
      settle(4);
      check("R10 divisor 0 acts as 2", last_len, 21);
      wr(1'b0, 8);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_latency;
      t_formats;
      t_data_edges;
      t_back2back;
      t_tail;
      t_disable;
      t_cfg_active;
      t_min_div;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule